// File: doc/BRIEF.md
# CEC Signal Free Time Timer

This block decides when a CEC initiator may begin a transmission. It measures how long the shared bus has stayed high since its last low period and compares that idle time with a required signal-free time. The idle time is kept in half-bit-period units: one nominal data-bit period is 2.4 ms, so one unit is 1.2 ms. A unit is built from a parameterized number of timing tick pulses.

A 3-bit selector sets the required time. A non-zero selector value picks a fixed wait. A zero value hands the choice to hardware, which uses a small history register. That register records whether this node is a new initiator, whether its last transmission succeeded, or whether its last transmission failed. Outcome pulses from the transmitter update the history, and a pulse reporting a start by another node returns it to the new-initiator state. The single output tells the transmitter that the bus has been free long enough to start. Arbitration and bit transmission belong to other blocks.

Top module: `cec_sft_timer`

## Requirements
- R1: After reset `bus_free_o` is 0, the idle count is zero and the history is new-initiator.
- R2: A selector `free_sel_i` value k from 1 to 7 sets the wait to 2k-1 half periods (0.5 to 6.5 bit periods in steps of one bit period).
- R3: With selector 0 and history new-initiator, the wait is 8 half periods (4 bit periods).
- R4: With selector 0, after a `tx_done_ok_i` pulse the wait is 12 half periods (6 bit periods).
- R5: With selector 0, after a pulse on any one of `arb_loss_i`, `tx_error_i`, `tx_underrun_i` or `ack_miss_i` the wait is 5 half periods (2.5 bit periods).
- R6: A `peer_start_i` pulse returns the history to new-initiator.
- R7: `bus_free_o` drops in the same cycle that `bus_i` is 0, and the idle count restarts from zero when the bus returns high.
- R8: One half period is exactly `HALF_TICKS` cycles with `tick_i` high while `bus_i` is high; cycles without a tick do not advance the count.
- R9: The idle count saturates, so `bus_free_o` stays 1 for as long as the bus remains idle past the wait.
- R10: When outcome pulses coincide, failure takes priority over success, and success takes priority over a peer start.
- R11: `bus_free_o` is 1 exactly while the bus is high and the idle count is at or above the selected wait. A change of the selector takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timing tick, one cycle wide |
| bus_i | input | 1 | Synchronized bus level, 1 = idle/high |
| free_sel_i | input | 3 | Signal-free time selector, 0 = history-driven |
| tx_done_ok_i | input | 1 | Pulse: own transmission ended successfully |
| arb_loss_i | input | 1 | Pulse: own transmission lost arbitration |
| tx_error_i | input | 1 | Pulse: own transmission hit a bit error |
| tx_underrun_i | input | 1 | Pulse: own transmission ran out of data |
| ack_miss_i | input | 1 | Pulse: own transmission was not acknowledged |
| peer_start_i | input | 1 | Pulse: another node started bus activity |
| bus_free_o | output | 1 | Bus free for at least the selected wait; may start |

## Verification
A wrong idle count shows up as `bus_free_o` rising one or more half periods too early or too late. For that reason every threshold is probed at the tick just before it and at the tick that reaches it. A corrupted history register changes only the selector-0 wait, so every history transition is followed by a selector-0 boundary probe that tells 5, 8 and 12 half periods apart. A count that fails to clear on a low bus is exposed by the next idle period, which must again need the full wait.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;

  typedef enum logic [1:0] {
    HIST_NEW  = 2'd0,
    HIST_OK   = 2'd1,
    HIST_FAIL = 2'd2
  } hist_e;

  localparam int THR_W      = 4;
  localparam int HALVES_NEW = 8;
  localparam int HALVES_OK  = 12;
  localparam int HALVES_BAD = 5;

  // Required idle time in half-bit periods.
  function automatic logic [THR_W-1:0] wait_halves(input logic [2:0] sel, input hist_e hist);
    logic [THR_W-1:0] res;
    if (sel != 3'd0) begin
      res = {sel, 1'b0} - 4'd1;
    end else begin
      unique case (hist)
        HIST_OK:   res = THR_W'(HALVES_OK);
        HIST_FAIL: res = THR_W'(HALVES_BAD);
        default:   res = THR_W'(HALVES_NEW);
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/sft_idle_timer.sv
module sft_idle_timer #(
  parameter int HALF_TICKS = 12,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_i,
  output logic [CNT_W-1:0] half_cnt_o,
  output logic             half_step_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sub_last;
  logic saturated;

  assign saturated   = (half_cnt_o == CNT_MAX);
  assign half_step_o = bus_i && tick_i && sub_last;

  generate
    if (HALF_TICKS == 1) begin : g_direct
      assign sub_last = 1'b1;
    end else begin : g_prescale
      localparam int SUB_W = $clog2(HALF_TICKS);
      logic [SUB_W-1:0] sub_q;
      assign sub_last = (sub_q == SUB_W'(HALF_TICKS - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !bus_i) begin
          sub_q <= '0;
        end else if (tick_i) begin
          sub_q <= sub_last ? '0 : sub_q + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_i) begin
      half_cnt_o <= '0;
    end else if (half_step_o && !saturated) begin
      half_cnt_o <= half_cnt_o + 1'b1;
    end
  end

  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_i |=> half_cnt_o == '0);  // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_cnt_o != $past(half_cnt_o)) |->
      ((half_cnt_o == $past(half_cnt_o) + 1'b1) || (half_cnt_o == '0)));  // R8

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && bus_i) |=> $stable(half_cnt_o) || (half_cnt_o == '0));  // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_i && half_cnt_o == CNT_MAX) |=> half_cnt_o == CNT_MAX);  // R9

endmodule

// File: rtl/sft_history.sv
module sft_history
  import cec_sft_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ok_i,
  input  logic  fail_i,
  input  logic  peer_i,
  output hist_e hist_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_o <= HIST_NEW;
    end else if (fail_i) begin
      hist_o <= HIST_FAIL;
    end else if (ok_i) begin
      hist_o <= HIST_OK;
    end else if (peer_i) begin
      hist_o <= HIST_NEW;
    end
  end

  AST_FAIL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> hist_o == HIST_FAIL);  // R10

  AST_OK_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_i && !fail_i) |=> hist_o == HIST_OK);  // R4

  AST_PEER_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_i && !ok_i && !fail_i) |=> hist_o == HIST_NEW);  // R6

  AST_HIST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!peer_i && !ok_i && !fail_i) |=> $stable(hist_o));  // R5

endmodule

// File: rtl/cec_sft_timer.sv
module cec_sft_timer
  import cec_sft_pkg::*;
#(
  parameter int HALF_TICKS = 12,
  parameter int CNT_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_i,
  input  logic [2:0] free_sel_i,
  input  logic       tx_done_ok_i,
  input  logic       arb_loss_i,
  input  logic       tx_error_i,
  input  logic       tx_underrun_i,
  input  logic       ack_miss_i,
  input  logic       peer_start_i,
  output logic       bus_free_o
);

  logic [CNT_W-1:0] half_cnt;
  logic             half_step;
  logic             tx_failed;
  hist_e            hist;
  logic [THR_W-1:0] thr;
  logic             reached;

  assign tx_failed = arb_loss_i | tx_error_i | tx_underrun_i | ack_miss_i;

  sft_idle_timer #(
    .HALF_TICKS(HALF_TICKS),
    .CNT_W     (CNT_W)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .bus_i      (bus_i),
    .half_cnt_o (half_cnt),
    .half_step_o(half_step)
  );

  sft_history u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .ok_i  (tx_done_ok_i),
    .fail_i(tx_failed),
    .peer_i(peer_start_i),
    .hist_o(hist)
  );

  assign thr        = wait_halves(free_sel_i, hist);
  assign reached    = ({{(32-CNT_W){1'b0}}, half_cnt} >= {{(32-THR_W){1'b0}}, thr});
  assign bus_free_o = bus_i && reached;

  AST_FREE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_o |-> $past(bus_i));  // R7

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (half_step && half_cnt != {CNT_W{1'b1}}) |=> half_cnt != '0);  // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (half_cnt == '0) && (hist == HIST_NEW));  // R1

endmodule

// File: tb/test_cec_sft_timer.sv
module test_cec_sft_timer;

  localparam int CLK_PERIOD = 10;
  localparam int HT         = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_i = 1'b1;
  logic [2:0] free_sel_i = 3'd0;
  logic       tx_done_ok_i = 1'b0;
  logic       arb_loss_i = 1'b0;
  logic       tx_error_i = 1'b0;
  logic       tx_underrun_i = 1'b0;
  logic       ack_miss_i = 1'b0;
  logic       peer_start_i = 1'b0;
  logic       bus_free_o;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cec_sft_timer #(.HALF_TICKS(HT), .CNT_W(4)) i_cec_sft_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .bus_i        (bus_i),
    .free_sel_i   (free_sel_i),
    .tx_done_ok_i (tx_done_ok_i),
    .arb_loss_i   (arb_loss_i),
    .tx_error_i   (tx_error_i),
    .tx_underrun_i(tx_underrun_i),
    .ack_miss_i   (ack_miss_i),
    .peer_start_i (peer_start_i),
    .bus_free_o   (bus_free_o)
  );

  // Bench view of the wait: table of bit periods times two.
  function automatic int model_halves(input int sel, input string hist);
    if (sel > 0) return sel * 2 - 1;
    if (hist == "ok")   return 12;
    if (hist == "fail") return 5;
    return 8;
  endfunction

  task automatic chk(input logic exp, input string req);
    vectors++;
    if (bus_free_o !== exp) begin
      errors++;
      $display("FAIL %s: bus_free_o=%0b expected %0b at %0t", req, bus_free_o, exp, $time);
    end
  endtask

  task automatic restart();
    @(negedge clk); tick_i = 1'b0; bus_i = 1'b0;
    @(negedge clk); bus_i = 1'b1;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic boundary(input int sel, input int halves, input string req);
    free_sel_i = 3'(sel);
    restart();
    ticks(halves * HT - 1, 0);
    chk(1'b0, req);
    ticks(1, 0);
    chk(1'b1, req);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_done_ok_i  = 1'b1;
      1: arb_loss_i    = 1'b1;
      2: tx_error_i    = 1'b1;
      3: tx_underrun_i = 1'b1;
      4: ack_miss_i    = 1'b1;
      default: peer_start_i = 1'b1;
    endcase
    @(negedge clk);
    {tx_done_ok_i, arb_loss_i, tx_error_i, tx_underrun_i, ack_miss_i, peer_start_i} = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 after reset");
    boundary(0, model_halves(0, "new"), "R1 R3 history new after reset");
  endtask

  task automatic t_fixed();
    for (int s = 1; s <= 7; s++) boundary(s, model_halves(s, "new"), "R2 fixed wait");
  endtask

  task automatic t_success();
    pulse(0);
    boundary(0, model_halves(0, "ok"), "R4 wait after success");
  endtask

  task automatic t_fail();
    for (int k = 1; k <= 4; k++) begin
      pulse(5);
      pulse(k);
      boundary(0, model_halves(0, "fail"), "R5 wait after failure");
    end
  endtask

  task automatic t_peer();
    pulse(0);
    pulse(5);
    boundary(0, model_halves(0, "new"), "R6 peer start gives new");
  endtask

  task automatic t_low();
    boundary(1, 1, "R7 setup");
    @(negedge clk); bus_i = 1'b0;
    #1 chk(1'b0, "R7 drop same cycle");
    @(negedge clk); bus_i = 1'b1;
    #1 chk(1'b0, "R7 restart from zero");
    ticks(HT - 1, 0);
    chk(1'b0, "R7 restart count");
    ticks(1, 0);
    chk(1'b1, "R7 restart count");
  endtask

  task automatic t_sparse();
    free_sel_i = 3'd2;
    restart();
    ticks(3 * HT - 1, 3);
    chk(1'b0, "R8 sparse ticks");
    repeat (20) @(negedge clk);
    chk(1'b0, "R8 no tick no advance");
    ticks(1, 2);
    chk(1'b1, "R8 sparse ticks");
  endtask

  task automatic t_sat();
    free_sel_i = 3'd7;
    restart();
    ticks(20 * HT, 0);
    chk(1'b1, "R9 saturated stays free");
    ticks(10 * HT, 0);
    chk(1'b1, "R9 saturated stays free");
  endtask

  task automatic t_prio();
    @(negedge clk); tx_done_ok_i = 1'b1; arb_loss_i = 1'b1;
    @(negedge clk); tx_done_ok_i = 1'b0; arb_loss_i = 1'b0;
    boundary(0, model_halves(0, "fail"), "R10 failure beats success");
    @(negedge clk); tx_done_ok_i = 1'b1; peer_start_i = 1'b1;
    @(negedge clk); tx_done_ok_i = 1'b0; peer_start_i = 1'b0;
    boundary(0, model_halves(0, "ok"), "R10 success beats peer");
  endtask

  task automatic t_selchg();
    free_sel_i = 3'd3;
    restart();
    ticks(5 * HT, 0);
    chk(1'b1, "R11 reached wait");
    free_sel_i = 3'd7;
    #1 chk(1'b0, "R11 longer selector");
    free_sel_i = 3'd2;
    #1 chk(1'b1, "R11 shorter selector");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_success();
    t_fail();
    t_peer();
    t_low();
    t_sparse();
    t_sat();
    t_prio();
    t_selchg();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule